// File: doc/BRIEF.md
# Square-Root Carry-Select Adder, 64 bit

This block adds two 64-bit operands and a carry-in, with no clock. It returns a 64-bit sum and a carry-out. The operand width is cut into eleven groups of unequal size. Going up from bit 0, the sizes are 2, 2, 3, 4, 5, 6, 7, 8, 9, 10 and 8 bits. This non-uniform schedule is chosen so that the carry reaching each group arrives at about the same time as that group's local result.

The lowest group is a plain ripple-carry adder, and the external carry-in feeds it directly. Every higher group has a single ripple-carry adder that assumes a carry-in of zero. Beside it sits an increment network that forms the carry-in-of-one result. It does this by complementing the zero-assumed sum from its least significant bit up to and including the first zero bit. That group's carry-in-of-one carry-out is the zero-assumed carry OR "all sum bits are one". The carry leaving the group below then picks, through 2-to-1 selection, both the sum bits and the carry-out of the group. The slowest path is a carry that enters at the bottom group and is handed up through every selection stage to the top.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For all operands, {cout, s} equals the 65-bit value a + b + cin.
- R2: With a all ones, b zero and cin one, s is zero and cout is one, so the carry crosses all eleven groups.
- R3: With a and b both zero, s equals cin, zero-extended to 64 bits, and cout is zero.
- R4: The carry-in enters the lowest group (bits 1:0) directly. With a = 1, b = 0 and cin = 1, s is 2.
- R5: For every bit position k from 1 to 63, a = 2^k - 1, b = 1 and cin = 0 gives s = 2^k and cout = 0. For k = 64 (a all ones), the sum is zero and cout is one.
- R6: A carry generated inside the top group alone sets cout. With a = b = 2^63 and cin = 0, the result is s = 0 and cout = 1.
- R7: When every bit propagates but none generates (a XOR b all ones, a AND b zero), cout equals cin and every sum bit equals NOT cin.
- R8: Groups begin at bit offsets 0, 2, 4, 7, 11, 16, 22, 29, 37, 46 and 56. The carry into each group equals the true carry out of the bits below its offset. Setting one group's bits all to one and adding 1 at that group's lowest bit yields a single one at the next group's offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| s | output | 64 | Sum |
| cout | output | 1 | Carry out of bit 63 |

## Verification
The bench first drives carry chains that stop at each of the 64 bit positions in turn. A wrong group offset, or a select wired to the wrong group's carry, would show up as a misplaced or lost carry exactly at one boundary. It then fills each group with ones and adds one at its base. This exercises the first-zero increment wrapping to zero; an increment network that forgets its carry-out when all bits are one would drop the carry into the next group. Long propagate-only patterns with each carry-in value check that no spurious carry appears. Random operands with a fixed seed cover the general sums.

// File: rtl/sqrt_csel_pkg.sv
package sqrt_csel_pkg;

  localparam int NUM_GRP = 11;

  // group widths from the least significant end
  localparam int GRP_SIZE [NUM_GRP] = '{2, 2, 3, 4, 5, 6, 7, 8, 9, 10, 8};

  // bit offset at which group g begins; g == NUM_GRP gives the total width
  function automatic int grp_lsb(input int g);
    int acc;
    acc = 0;
    for (int i = 0; i < g; i++) acc += GRP_SIZE[i];
    return acc;
  endfunction

  localparam int DATA_W = grp_lsb(NUM_GRP);

endpackage

// File: rtl/rca_group.sv
module rca_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] sum,
  output logic         co
);

  logic [W:0] c;

  assign c[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]  = a[i] ^ b[i] ^ c[i];
    assign c[i+1]  = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end

  assign co = c[W];

endmodule

// File: rtl/addone_fzd.sv
module addone_fzd #(
  parameter int W = 4
) (
  input  logic [W-1:0] s0,
  input  logic         c0,
  output logic [W-1:0] s1,
  output logic         c1
);

  // run[i] is high while every bit below i is one (no zero seen yet)
  logic [W:0] run;

  assign run[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s1[i]    = s0[i] ^ run[i];
    assign run[i+1] = run[i] & s0[i];
  end

  assign c1 = c0 | run[W];

endmodule

// File: rtl/csel_group.sv
module csel_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_ci,
  output logic [W-1:0] sum,
  output logic         co
);

  logic [W-1:0] sum_z;
  logic [W-1:0] sum_o;
  logic         co_z;
  logic         co_o;

  rca_group #(.W(W)) u_rca (
    .a   (a),
    .b   (b),
    .ci  (1'b0),
    .sum (sum_z),
    .co  (co_z)
  );

  addone_fzd #(.W(W)) u_inc (
    .s0 (sum_z),
    .c0 (co_z),
    .s1 (sum_o),
    .c1 (co_o)
  );

  for (genvar i = 0; i < W; i++) begin : g_mux
    assign sum[i] = sel_ci ? sum_o[i] : sum_z[i];
  end

  assign co = sel_ci ? co_o : co_z;

endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder
  import sqrt_csel_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] s,
  output logic              cout
);

  // grp_carry[g] is the carry entering group g
  logic [NUM_GRP:0] grp_carry;

  assign grp_carry[0] = cin;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int LSB = grp_lsb(g);
    localparam int W   = GRP_SIZE[g];

    if (g == 0) begin : g_base
      rca_group #(.W(W)) u_rca (
        .a   (a[LSB +: W]),
        .b   (b[LSB +: W]),
        .ci  (grp_carry[g]),
        .sum (s[LSB +: W]),
        .co  (grp_carry[g+1])
      );
    end else begin : g_sel
      csel_group #(.W(W)) u_csel (
        .a      (a[LSB +: W]),
        .b      (b[LSB +: W]),
        .sel_ci (grp_carry[g]),
        .sum    (s[LSB +: W]),
        .co     (grp_carry[g+1])
      );
    end
  end

  assign cout = grp_carry[NUM_GRP];

endmodule

// File: rtl/sqrt_csel_adder_chk.sv
module sqrt_csel_adder_chk
  import sqrt_csel_pkg::*;
(
  input logic [DATA_W-1:0] a,
  input logic [DATA_W-1:0] b,
  input logic              cin,
  input logic [DATA_W-1:0] s,
  input logic              cout,
  input logic [NUM_GRP:0]  grp_carry
);

  logic [DATA_W:0] full_ref;

  assign full_ref = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};

  always_comb begin
    assert_sum_R1: assert ({cout, s} == full_ref)
      else $error("R1 sum mismatch");
    if (a == '0 && b == '0) begin
      assert_zero_R3: assert (s == {{(DATA_W-1){1'b0}}, cin} && !cout)
        else $error("R3 zero operand result wrong");
    end
    if ((a ^ b) == '1 && (a & b) == '0) begin
      assert_prop_R7: assert (cout == cin && s == {DATA_W{~cin}})
        else $error("R7 propagate chain wrong");
    end
    if (a[DATA_W-1] && b[DATA_W-1]) begin
      assert_topgen_R6: assert (cout)
        else $error("R6 top group generate lost");
    end
    assert_lastcarry_R1: assert (grp_carry[NUM_GRP] == full_ref[DATA_W])
      else $error("R1 final carry wrong");
  end

  for (genvar g = 1; g < NUM_GRP; g++) begin : g_bnd
    localparam int OFF = grp_lsb(g);
    localparam logic [DATA_W-1:0] MASK = (DATA_W'(1) << OFF) - DATA_W'(1);
    logic [DATA_W:0] lo_sum;
    assign lo_sum = {1'b0, a & MASK} + {1'b0, b & MASK} + {{DATA_W{1'b0}}, cin};
    always_comb begin
      assert_grpcarry_R8: assert (grp_carry[g] == lo_sum[OFF])
        else $error("R8 carry into group %0d wrong", g);
    end
  end

endmodule

bind sqrt_csel_adder sqrt_csel_adder_chk u_chk (
  .a         (a),
  .b         (b),
  .cin       (cin),
  .s         (s),
  .cout      (cout),
  .grp_carry (grp_carry)
);

// File: tb/tb_sqrt_csel_adder.sv
module tb_sqrt_csel_adder;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;
  localparam int N_RAND     = 3000;

  logic        clk;
  logic        rst_n;
  logic [63:0] a;
  logic [63:0] b;
  logic        cin;
  logic [63:0] s;
  logic        cout;

  int checks;
  int fails;
  int cycles;
  bit done;

  sqrt_csel_adder dut (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .s    (s),
    .cout (cout)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [64:0] ref_add(input logic [63:0] x, input logic [63:0] y,
                                          input logic ci);
    return {1'b0, x} + {1'b0, y} + {64'd0, ci};
  endfunction

  task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic ci,
                       input string req);
    logic [64:0] exp;
    @(negedge clk);
    a   = x;
    b   = y;
    cin = ci;
    #(CLK_PERIOD/4);
    exp = ref_add(x, y, ci);
    checks++;
    if ({cout, s} !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h cin=%0d actual=%h_%h expected=%h_%h",
               req, x, y, ci, cout, s, exp[64], exp[63:0]);
    end
  endtask

  // watchdog
  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= WDOG_LIMIT && !done) begin
        fails++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WDOG_LIMIT);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int grp_w [11] = '{2, 2, 3, 4, 5, 6, 7, 8, 9, 10, 8};
    int base;
    int unsigned seed_val;
    logic [63:0] ra;
    logic [63:0] rb;
    logic [63:0] ones;
    checks = 0;
    fails  = 0;
    done   = 0;
    rst_n  = 1'b0;
    a      = '0;
    b      = '0;
    cin    = 1'b0;
    seed_val = $urandom(32'd20240611);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // initial state: zero in gives zero out
    @(negedge clk);
    checks++;
    if (s !== 64'd0 || cout !== 1'b0) begin
      fails++;
      $display("FAIL R3 idle actual=%h_%h expected=0_0", cout, s);
    end

    // R3 zero operands, both carry-in values
    apply(64'd0, 64'd0, 1'b0, "R3");
    apply(64'd0, 64'd0, 1'b1, "R3");
    // R4 carry-in lands in lowest group
    apply(64'd1, 64'd0, 1'b1, "R4");
    apply(64'd0, 64'd3, 1'b1, "R4");
    // R2 all ones plus one
    apply('1, 64'd0, 1'b1, "R2");
    apply(64'd0, '1, 1'b1, "R2");
    apply('1, 64'd1, 1'b0, "R2");
    // R6 generate in top group only
    apply(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, "R6");
    apply(64'hFF00_0000_0000_0000, 64'h0100_0000_0000_0000, 1'b0, "R6");
    // R7 propagate without generate
    apply('1, 64'd0, 1'b0, "R7");
    apply(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, "R7");
    apply(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, "R7");
    apply(64'h0F0F_F0F0_1234_5678, ~64'h0F0F_F0F0_1234_5678, 1'b1, "R7");

    // R5 carry chain ending at every bit position
    for (int k = 1; k < 64; k++) begin
      ones = (64'd1 << k) - 64'd1;
      apply(ones, 64'd1, 1'b0, "R5");
      apply(ones, 64'd0, 1'b1, "R5");
    end
    apply('1, 64'd1, 1'b0, "R5");

    // R8 each group full of ones plus one at its base
    base = 0;
    for (int g = 0; g < 11; g++) begin
      ones = ((64'd1 << grp_w[g]) - 64'd1) << base;
      if (grp_w[g] + base == 64) ones = ~((64'd1 << base) - 64'd1);
      apply(ones, 64'd1 << base, 1'b0, "R8");
      apply(ones, 64'd0, (base == 0) ? 1'b1 : 1'b0, "R8");
      base += grp_w[g];
    end

    // R1 random operands, some with biased carry runs
    for (int i = 0; i < N_RAND; i++) begin
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      if (i % 4 == 1) rb = ~ra ^ (64'd1 << (i % 64));
      if (i % 4 == 2) ra = ra | 64'hFFFF_FFFF_0000_0000;
      apply(ra, rb, 1'($urandom() & 1), "R1");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule